// File: doc/BRIEF.md
# Four-Level Priority Interrupt Controller

This controller sits beside a small 8-bit processor core. It gathers six direct request lines and one composite line, and it presents at most one request to the core, together with a 3-bit vector index. Each request line is synchronised to the clock. A rising edge on a line latches a pending flag. A request competes only when its own enable bit and the global enable bit are both set. Line 6 is built from two sub-sources, a transfer-busy signal and a one-second tick. Each sub-source has its own enable and its own edge-set flag, and the two gated flags are OR-ed to form line 6.

Each of six priority groups takes a 2-bit level. The high bit of the level comes from one priority register and the low bit from another. Line n belongs to group n for lines 0 to 5, and line 6 shares the level of group 5. The highest level wins. Within a level, the lower line index wins. When the core acknowledges, the winner's level is marked in service. A return strobe drops the highest level in service. A new request reaches the core only if its level is strictly above every level in service. Acknowledging lines 0 to 5 clears their flags. The sub-source flags stay set until software clears them.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, every register reads 0x00, `irq_req_o` is 0 and `irq_vec_o` is 0.
- R2: A rising edge on `ext_irq_i[n]` sets flag bit n of the FLAG register (address 1, bits 5:0), whether or not line n is enabled. The flag appears within four clock edges.
- R3: Line n (0 to 6) can request only while its enable bit n in the ENA register (address 0) is 1 and the global enable, ENA bit 7, is also 1. If either bit is 0, no request is presented.
- R4: The level of group g is {PHI[g], PLO[g]}, where PLO is at address 3 and PHI is at address 4. The values 00, 01, 10 and 11 give levels 0 (lowest) through 3 (highest). Line 6 uses group 5. PLO bits 7:6 are kept and read back but do not affect priority. PHI bits 7:6 read 0.
- R5: Among the pending, enabled lines, the one with the highest level is presented. A tie goes to the lowest line index.
- R6: When `irq_ack_i` is high while a request is presented, the flag of the presented line (if it is 0 to 5) is cleared at that edge.
- R7: SUB register (address 2): bit 0 enables transfer-busy and bit 1 enables the tick. Bit 4 is the transfer-busy flag and bit 5 is the tick flag. Each flag is set on a rising edge of its input. FLAG bit 6 reads the OR of each sub-flag AND its enable, and this OR is line 6. An acknowledge never clears a sub-flag. Writing SUB clears the sub-flags.
- R8: An acknowledge marks the presented level as in service. After that, a request is presented only if its level is strictly above the highest level in service.
- R9: A pulse on `irq_reti_i` clears the highest in-service level. The next lower in-service level then governs preemption.
- R10: A software write to FLAG or SUB in the same cycle that a hardware edge sets a flag leaves that flag set. Without a simultaneous edge, the written value is stored.
- R11: Reads are registered: `reg_rdata_o` shows the addressed register one clock edge after the address is presented. Addresses 5 to 7 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_irq_i | input | 6 | Direct request lines 0 to 5 |
| xfer_busy_i | input | 1 | Transfer-busy sub-source of line 6 |
| sec_tick_i | input | 1 | One-second tick sub-source of line 6 |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_we_i | input | 1 | Register write enable |
| reg_rdata_o | output | 8 | Registered read data |
| irq_req_o | output | 1 | A request is presented to the core |
| irq_vec_o | output | 3 | Vector index of the presented line, 0 when idle |
| irq_ack_i | input | 1 | Core acknowledges the presented vector |
| irq_reti_i | input | 1 | Core returns from the current handler |

## Verification
The assertions check four rules on every cycle. A hardware edge always leaves its flag set. An acknowledge clears the flag of a direct line and never a sub-source flag. The global enable silences the request. Each acknowledge adds one in-service level and each return drops exactly one. They also check that the arbiter winner is always a pending line. The bench scenarios are needed for the rest: the actual choice between competing levels and index ties, the split of each level across the two priority registers, the mapping of line 6 onto group 5, and the preemption sequence through nested returns, since each of these depends on register contents arranged over many cycles.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int N_DIRECT = 6;
  localparam int N_LINES  = N_DIRECT + 1;
  localparam int N_SUB    = 2;
  localparam int VEC_W    = $clog2(N_LINES);
  localparam int LVL_W    = 2;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_ENA  = 3'd0,
    RA_FLAG = 3'd1,
    RA_SUB  = 3'd2,
    RA_PLO  = 3'd3,
    RA_PHI  = 3'd4
  } reg_addr_e;

  // Level of a group: high bit from one register, low bit from the other.
  function automatic logic [LVL_W-1:0] group_level(
    input logic [N_DIRECT-1:0] lo,
    input logic [N_DIRECT-1:0] hi,
    input int                  grp
  );
    return {hi[grp], lo[grp]};
  endfunction

  // Line 6 shares the last group's level.
  function automatic int group_of_line(input int line);
    return (line < N_DIRECT) ? line : N_DIRECT - 1;
  endfunction
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] rise_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        s1_q   <= raw_i[g];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end
    assign rise_o[g] = s2_q & ~prev_q;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N  = 7,
  parameter int LW = 2,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pend_i,
  input  logic [N*LW-1:0] lvl_i,
  output logic          win_valid_o,
  output logic [IW-1:0] win_idx_o,
  output logic [LW-1:0] win_lvl_o
);
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    win_lvl_o   = '0;
    for (int i = 0; i < N; i++) begin
      // strictly greater keeps the lower index on a tie
      if (pend_i[i] && (!win_valid_o || lvl_i[i*LW +: LW] > win_lvl_o)) begin
        win_valid_o = 1'b1;
        win_idx_o   = IW'(i);
        win_lvl_o   = lvl_i[i*LW +: LW];
      end
    end
  end

  assert_winner_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> pend_i[win_idx_o]);
endmodule

// File: rtl/irq_nest_tracker.sv
module irq_nest_tracker #(
  parameter int LW = 2,
  localparam int NL = 1 << LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [LW-1:0] push_lvl_i,
  input  logic          pop_i,
  output logic          active_o,
  output logic [LW-1:0] top_lvl_o
);
  logic [NL-1:0] insvc_q, insvc_d;

  always_comb begin
    active_o  = 1'b0;
    top_lvl_o = '0;
    for (int l = 0; l < NL; l++) begin
      if (insvc_q[l]) begin
        active_o  = 1'b1;
        top_lvl_o = LW'(l);
      end
    end
  end

  always_comb begin
    insvc_d = insvc_q;
    if (pop_i && active_o) insvc_d[top_lvl_o] = 1'b0;
    if (push_i)            insvc_d[push_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) insvc_q <= '0;
    else        insvc_q <= insvc_d;
  end

  assert_push_marks_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> insvc_q[$past(push_lvl_i)]);

  assert_pop_drops_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && active_o) |=>
      ($countones(insvc_q) + 1 == $countones($past(insvc_q))));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        ext_irq_i,
  input  logic              xfer_busy_i,
  input  logic              sec_tick_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic              reg_we_i,
  output logic [7:0]        reg_rdata_o,
  output logic              irq_req_o,
  output logic [2:0]        irq_vec_o,
  input  logic              irq_ack_i,
  input  logic              irq_reti_i
);
  localparam int RAW_W = N_DIRECT + N_SUB;

  logic [DATA_W-1:0]   en_q;
  logic [N_DIRECT-1:0] flag_q, flag_d;
  logic [N_SUB-1:0]    sub_en_q, sub_fl_q, sub_fl_d;
  logic [DATA_W-1:0]   plo_q;
  logic [N_DIRECT-1:0] phi_q;
  logic [DATA_W-1:0]   rdata_q, rd_mux;

  // named internal events
  logic [RAW_W-1:0]    rise;
  logic [N_DIRECT-1:0] line_rise;
  logic [N_SUB-1:0]    sub_rise;
  logic                glob_en, line6, ack_evt;
  logic                wr_ena, wr_flag, wr_sub, wr_plo, wr_phi;
  logic [N_DIRECT-1:0] ack_line_mask;
  logic [N_LINES-1:0]  pend;
  logic [N_LINES*LVL_W-1:0] lvl_vec;
  logic                win_valid, svc_active;
  logic [VEC_W-1:0]    win_idx;
  logic [LVL_W-1:0]    win_lvl, svc_lvl;

  irq_edge_sync #(.W(RAW_W)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({sec_tick_i, xfer_busy_i, ext_irq_i}),
    .rise_o (rise)
  );
  assign line_rise = rise[N_DIRECT-1:0];
  assign sub_rise  = rise[RAW_W-1:N_DIRECT];

  assign glob_en = en_q[DATA_W-1];
  assign wr_ena  = reg_we_i && (reg_addr_i == RA_ENA);
  assign wr_flag = reg_we_i && (reg_addr_i == RA_FLAG);
  assign wr_sub  = reg_we_i && (reg_addr_i == RA_SUB);
  assign wr_plo  = reg_we_i && (reg_addr_i == RA_PLO);
  assign wr_phi  = reg_we_i && (reg_addr_i == RA_PHI);

  assign line6 = |(sub_fl_q & sub_en_q);

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    if (i < N_DIRECT) begin : g_direct
      assign pend[i] = flag_q[i] & en_q[i] & glob_en;
    end else begin : g_composite
      assign pend[i] = line6 & en_q[i] & glob_en;
    end
    assign lvl_vec[i*LVL_W +: LVL_W] =
      group_level(plo_q[N_DIRECT-1:0], phi_q, group_of_line(i));
  end

  irq_arbiter #(.N(N_LINES), .LW(LVL_W)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .pend_i      (pend),
    .lvl_i       (lvl_vec),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx),
    .win_lvl_o   (win_lvl)
  );

  irq_nest_tracker #(.LW(LVL_W)) u_nest (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (ack_evt),
    .push_lvl_i (win_lvl),
    .pop_i      (irq_reti_i),
    .active_o   (svc_active),
    .top_lvl_o  (svc_lvl)
  );

  assign irq_req_o = win_valid && (!svc_active || (win_lvl > svc_lvl));
  assign irq_vec_o = irq_req_o ? win_idx : '0;
  assign ack_evt   = irq_ack_i && irq_req_o;
  assign ack_line_mask = ack_evt ? (N_DIRECT'(1) << irq_vec_o) : '0;

  // flag update: write, then acknowledge clear, then hardware set wins
  always_comb begin
    flag_d = wr_flag ? reg_wdata_i[N_DIRECT-1:0] : flag_q;
    flag_d = (flag_d & ~ack_line_mask) | line_rise;
    sub_fl_d = wr_sub ? reg_wdata_i[5:4] : sub_fl_q;
    sub_fl_d = sub_fl_d | sub_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      flag_q   <= '0;
      sub_en_q <= '0;
      sub_fl_q <= '0;
      plo_q    <= '0;
      phi_q    <= '0;
    end else begin
      flag_q   <= flag_d;
      sub_fl_q <= sub_fl_d;
      if (wr_ena) en_q     <= reg_wdata_i;
      if (wr_sub) sub_en_q <= reg_wdata_i[N_SUB-1:0];
      if (wr_plo) plo_q    <= reg_wdata_i;
      if (wr_phi) phi_q    <= reg_wdata_i[N_DIRECT-1:0];
    end
  end

  always_comb begin
    case (reg_addr_i)
      RA_ENA:  rd_mux = en_q;
      RA_FLAG: rd_mux = {1'b0, line6, flag_q};
      RA_SUB:  rd_mux = {2'b00, sub_fl_q, 2'b00, sub_en_q};
      RA_PLO:  rd_mux = plo_q;
      RA_PHI:  rd_mux = {2'b00, phi_q};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rd_mux;
  end
  assign reg_rdata_o = rdata_q;

  assert_hw_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (line_rise != '0) |=> ((flag_q & $past(line_rise)) == $past(line_rise)));

  assert_ack_clears_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && !wr_flag && ((ack_line_mask & line_rise) == '0)) |=>
      ((flag_q & $past(ack_line_mask)) == '0));

  assert_sub_kept_on_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && !wr_sub) |=> ((sub_fl_q & $past(sub_fl_q)) == $past(sub_fl_q)));

  assert_global_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> !irq_req_o);
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_ENA = 3'd0, A_FLAG = 3'd1, A_SUB = 3'd2,
                         A_PLO = 3'd3, A_PHI = 3'd4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] raw = '0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0, ack = 1'b0, reti = 1'b0;
  logic [7:0] rdata;
  logic       req;
  logic [2:0] vec;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ext_irq_i(raw[5:0]), .xfer_busy_i(raw[6]),
    .sec_tick_i(raw[7]), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_we_i(we), .reg_rdata_o(rdata), .irq_req_o(req), .irq_vec_o(vec),
    .irq_ack_i(ack), .irq_reti_i(reti)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk); raw[idx] = 1'b1;
    repeat (4) @(negedge clk);
    raw[idx] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_reti();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
  endtask

  task automatic expect_req(input string tag, input int r, input int v);
    @(negedge clk);
    check({tag, " req"}, int'(req), r);
    check({tag, " vec"}, int'(vec), v);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 req", int'(req), 0);
    check("R1 vec", int'(vec), 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R1 reg", int'(d), 0);
    end
    rd(3'd6, d); check("R11 unmapped", int'(d), 0);
  endtask

  task automatic t_enable();
    logic [7:0] d;
    wr(A_ENA, 8'h80);
    pulse(2);
    rd(A_FLAG, d); check("R2 flag without enable", int'(d), 8'h04);
    expect_req("R3 line disabled", 0, 0);
    wr(A_ENA, 8'h84);
    expect_req("R3 enabled", 1, 2);
    wr(A_ENA, 8'h04);
    expect_req("R3 global off", 0, 0);
    wr(A_FLAG, 8'h00);
    rd(A_FLAG, d); check("R10 plain write", int'(d), 0);
    wr(A_ENA, 8'h00);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    wr(A_ENA, 8'h9A);
    wr(A_PLO, 8'h02); wr(A_PHI, 8'h08);
    pulse(1); pulse(3); pulse(4);
    expect_req("R5 level2 wins", 1, 3);
    wr(A_PHI, 8'h00);
    expect_req("R4 low bit level1", 1, 1);
    wr(A_PLO, 8'hC0);
    expect_req("R5 tie lowest index", 1, 1);
    rd(A_PLO, d); check("R4 PLO upper kept", int'(d), 8'hC0);
    wr(A_PLO, 8'h00);
    wr(A_PHI, 8'h10);
    expect_req("R4 high bit level2", 1, 4);
    wr(A_PHI, 8'hC0);
    rd(A_PHI, d); check("R4 PHI upper read 0", int'(d), 0);
    expect_req("R4 PHI upper no effect", 1, 1);
    wr(A_PHI, 8'h00); wr(A_FLAG, 8'h00); wr(A_ENA, 8'h00);
  endtask

  task automatic t_nesting();
    logic [7:0] d;
    wr(A_ENA, 8'h9A);
    pulse(1); pulse(3); pulse(4);
    expect_req("R5 first", 1, 1);
    do_ack();
    expect_req("R8 equal level blocked", 0, 0);
    rd(A_FLAG, d); check("R6 ack clears flag", int'(d), 8'h18);
    wr(A_PLO, 8'h10); wr(A_PHI, 8'h10);
    expect_req("R8 higher preempts", 1, 4);
    do_ack();
    expect_req("R8 nested blocked", 0, 0);
    rd(A_FLAG, d); check("R6 second clear", int'(d), 8'h08);
    do_reti();
    expect_req("R9 lower still in service", 0, 0);
    do_reti();
    expect_req("R9 all returned", 1, 3);
    do_ack(); do_reti();
    expect_req("R9 idle", 0, 0);
    rd(A_FLAG, d); check("R6 flags empty", int'(d), 0);
    wr(A_PLO, 8'h00); wr(A_PHI, 8'h00); wr(A_ENA, 8'h00);
  endtask

  task automatic t_line6();
    logic [7:0] d;
    wr(A_ENA, 8'hC0);
    wr(A_SUB, 8'h01);
    pulse(6);
    rd(A_SUB, d);  check("R7 sub flag", int'(d), 8'h11);
    rd(A_FLAG, d); check("R7 line6 flag", int'(d), 8'h40);
    expect_req("R7 line6 request", 1, 6);
    do_ack();
    expect_req("R8 line6 in service", 0, 0);
    rd(A_SUB, d); check("R7 kept on ack", int'(d), 8'h11);
    do_reti();
    expect_req("R7 still pending", 1, 6);
    wr(A_ENA, 8'hC1);
    pulse(0);
    expect_req("R5 tie line0", 1, 0);
    wr(A_PHI, 8'h20);
    expect_req("R4 line6 uses group5", 1, 6);
    wr(A_PHI, 8'h00); wr(A_FLAG, 8'h00);
    wr(A_SUB, 8'h01);
    rd(A_FLAG, d); check("R7 software clear", int'(d), 0);
    expect_req("R7 cleared no req", 0, 0);
    pulse(7);
    rd(A_SUB, d);  check("R7 tick flag", int'(d), 8'h21);
    rd(A_FLAG, d); check("R7 tick gated", int'(d), 0);
    expect_req("R7 gated no req", 0, 0);
    wr(A_SUB, 8'h00); wr(A_ENA, 8'h00);
  endtask

  task automatic t_hw_wins();
    logic [7:0] d;
    @(negedge clk); raw[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); addr = A_FLAG; wdata = 8'h00; we = 1'b1;
    @(negedge clk); we = 1'b0; raw[0] = 1'b0;
    rd(A_FLAG, d); check("R10 hw set wins", int'(d), 8'h01);
    wr(A_FLAG, 8'h00);
    rd(A_FLAG, d); check("R10 later write clears", int'(d), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_priority();
    t_nesting();
    t_line6();
    t_hw_wins();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule